// File: doc/BRIEF.md
# Reordered Access Address Set

This block sits inside a private cache controller and remembers the cache lines touched by memory accesses that the core completed ahead of an older, still pending access, where the access has reached a point at which it would not be undone if another core observed it. While such a line is held, any coherence request arriving from outside for that line is refused with a negative acknowledgement (nack). The requester then has to retry later. This keeps the out-of-order access invisible until it is back in program order.

The core offers candidate accesses on an allocate port. Each candidate carries its line address, a sequence tag and qualifying flags. The block keeps only the candidates that qualify. When an access stops running ahead of older ones, the core releases it by tag, and releases may come in any order. Every snoop is compared against all held lines, and a pass or nack verdict appears one cycle later. A full indication tells the core to stop issuing further reordered accesses. A flush empties the set in one cycle when the core rolls back.

Top module: `reorder_addr_set`

## Requirements
- R1: An allocate request is stored only when both its reordered flag and its not-squashable flag are 1. Otherwise the set is left unchanged.
- R2: A store candidate (`alloc_is_store`=1) is stored only if it has obtained exclusive permission without writing its data (`alloc_data_written`=0). A store with `alloc_data_written`=1 is not stored.
- R3: A snoop whose line address (address bits above the low OFF_W offset bits) equals that of a held entry gets `snp_nack`=1. The offset bits play no part in the comparison.
- R4: A snoop that matches no held entry gets `snp_resp_valid`=1 with `snp_nack`=0 (pass).
- R5: A release with tag T removes every held entry tagged T, whatever the allocation order. Entries with other tags stay held.
- R6: `full` is 1 exactly when all DEPTH entries are held. An allocate request arriving while full is dropped.
- R7: `flush`=1 empties the set at the next clock edge. An allocate request in the same cycle is dropped.
- R8: The verdict for a snoop presented in cycle N appears in cycle N+1, and `snp_resp_valid` is 1 only in cycles that follow a snoop. The comparison uses the contents held before edge N's updates, so a same-cycle allocate is not yet visible and a same-cycle release or flush is still visible.
- R9: After reset the set is empty, `full`=0, `snp_resp_valid`=0 and `snp_nack`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Candidate access offered this cycle |
| alloc_addr | input | ADDR_W | Byte address of the candidate |
| alloc_tag | input | TAG_W | Sequence tag of the candidate |
| alloc_reordered | input | 1 | Candidate ran ahead of an older access |
| alloc_nonspec | input | 1 | Candidate would not be squashed if observed |
| alloc_is_store | input | 1 | Candidate is a store |
| alloc_data_written | input | 1 | Store has written its data (not only exclusive permission) |
| rel_valid | input | 1 | Release request |
| rel_tag | input | TAG_W | Tag to release |
| flush | input | 1 | Clear all entries (rollback) |
| snp_valid | input | 1 | Incoming coherence request |
| snp_addr | input | ADDR_W | Byte address of the coherence request |
| snp_resp_valid | output | 1 | Verdict valid (one cycle after snp_valid) |
| snp_nack | output | 1 | 1 = refuse the request, 0 = pass |
| full | output | 1 | All entries held; stall further reordered accesses |

## Verification
The bench builds the block with DEPTH=4, ADDR_W=16, OFF_W=6 and TAG_W=4. With DEPTH=4 the full condition and the dropped allocate are reached after a handful of allocations. The 64-byte line lets addresses at both ends of a line, and the first byte of the next line, probe the offset masking. Small tags make out-of-order release of a middle entry easy to arrange. The same-cycle orderings of snoop against allocate, release and flush are driven on purpose to pin down which contents the verdict reflects.

// File: rtl/ras_pkg.sv
package ras_pkg;

  typedef enum logic {
    SNP_PASS = 1'b0,
    SNP_NACK = 1'b1
  } snp_verdict_e;

  // Candidate qualifies: reordered, not squashable, and if a store, only
  // holding exclusive permission without its data written.
  function automatic logic ras_admit(input logic reordered,
                                     input logic nonspec,
                                     input logic is_store,
                                     input logic data_written);
    return reordered & nonspec & ~(is_store & data_written);
  endfunction

  function automatic snp_verdict_e ras_verdict(input logic any_hit);
    return any_hit ? SNP_NACK : SNP_PASS;
  endfunction

endpackage

// File: rtl/ras_entry.sv
module ras_entry #(
  parameter int LINE_W = 26,
  parameter int TAG_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              set_i,
  input  logic [LINE_W-1:0] line_i,
  input  logic [TAG_W-1:0]  tag_i,
  input  logic              rel_valid,
  input  logic [TAG_W-1:0]  rel_tag,
  output logic              valid_o,
  output logic [LINE_W-1:0] line_o,
  output logic              rel_hit_o
);

  logic              valid_q;
  logic [LINE_W-1:0] line_q;
  logic [TAG_W-1:0]  tag_q;

  assign rel_hit_o = valid_q & rel_valid & (tag_q == rel_tag);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      line_q  <= '0;
      tag_q   <= '0;
    end else if (flush) begin
      valid_q <= 1'b0;
    end else if (set_i) begin
      valid_q <= 1'b1;
      line_q  <= line_i;
      tag_q   <= tag_i;
    end else if (rel_hit_o) begin
      valid_q <= 1'b0;
    end
  end

  assign valid_o = valid_q;
  assign line_o  = line_q;

  AST_RELEASE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    rel_hit_o && !set_i |=> !valid_o); // R5

  AST_SET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    set_i && !flush |=> valid_o && line_o == $past(line_i)); // R1

endmodule

// File: rtl/ras_free_pick.sv
module ras_free_pick #(
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DEPTH-1:0] valid_vec,
  output logic [DEPTH-1:0] pick_o,
  output logic             full_o
);

  always_comb begin
    logic taken;
    taken  = 1'b0;
    pick_o = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!valid_vec[i] && !taken) begin
        pick_o[i] = 1'b1;
        taken     = 1'b1;
      end
    end
  end

  assign full_o = &valid_vec;

  AST_PICK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pick_o)); // R6

  AST_PICK_FREE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (pick_o & valid_vec) == '0); // R6

  AST_FULL_NO_PICK: assert property (@(posedge clk) disable iff (!rst_n)
    full_o |-> pick_o == '0); // R6

endmodule

// File: rtl/ras_snoop_cmp.sv
module ras_snoop_cmp
  import ras_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int LINE_W = 26
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         snp_valid,
  input  logic [LINE_W-1:0]            snp_line,
  input  logic [DEPTH-1:0]             ent_valid,
  input  logic [DEPTH-1:0][LINE_W-1:0] ent_line,
  output logic [DEPTH-1:0]             hit_vec_o,
  output logic                         resp_valid_o,
  output logic                         nack_o
);

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign hit_vec_o[g] = ent_valid[g] & (ent_line[g] == snp_line);
  end

  snp_verdict_e verdict;
  assign verdict = ras_verdict(|hit_vec_o);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid_o <= 1'b0;
      nack_o       <= 1'b0;
    end else begin
      resp_valid_o <= snp_valid;
      nack_o       <= snp_valid & (verdict == SNP_NACK);
    end
  end

  AST_RESP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid |=> resp_valid_o); // R8

  AST_RESP_ONLY_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !snp_valid |=> !resp_valid_o && !nack_o); // R8

endmodule

// File: rtl/reorder_addr_set.sv
module reorder_addr_set
  import ras_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 6,
  parameter int DEPTH  = 8,
  parameter int TAG_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  input  logic [ADDR_W-1:0] alloc_addr,
  input  logic [TAG_W-1:0]  alloc_tag,
  input  logic              alloc_reordered,
  input  logic              alloc_nonspec,
  input  logic              alloc_is_store,
  input  logic              alloc_data_written,
  input  logic              rel_valid,
  input  logic [TAG_W-1:0]  rel_tag,
  input  logic              flush,
  input  logic              snp_valid,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_resp_valid,
  output logic              snp_nack,
  output logic              full
);

  localparam int LINE_W = ADDR_W - OFF_W;

  function automatic logic [LINE_W-1:0] line_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:OFF_W];
  endfunction

  logic [DEPTH-1:0]             valid_vec;
  logic [DEPTH-1:0][LINE_W-1:0] line_arr;
  logic [DEPTH-1:0]             rel_hit_vec;
  logic [DEPTH-1:0]             pick_vec;
  logic [DEPTH-1:0]             hit_vec;
  logic                         admit_ok;
  logic                         alloc_go;

  assign admit_ok = ras_admit(alloc_reordered, alloc_nonspec,
                              alloc_is_store, alloc_data_written);
  assign alloc_go = alloc_valid & admit_ok & ~full & ~flush;

  ras_free_pick #(.DEPTH(DEPTH)) u_pick (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid_vec (valid_vec),
    .pick_o    (pick_vec),
    .full_o    (full)
  );

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    ras_entry #(.LINE_W(LINE_W), .TAG_W(TAG_W)) u_ent (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (flush),
      .set_i     (alloc_go & pick_vec[g]),
      .line_i    (line_of(alloc_addr)),
      .tag_i     (alloc_tag),
      .rel_valid (rel_valid),
      .rel_tag   (rel_tag),
      .valid_o   (valid_vec[g]),
      .line_o    (line_arr[g]),
      .rel_hit_o (rel_hit_vec[g])
    );
  end

  ras_snoop_cmp #(.DEPTH(DEPTH), .LINE_W(LINE_W)) u_cmp (
    .clk          (clk),
    .rst_n        (rst_n),
    .snp_valid    (snp_valid),
    .snp_line     (line_of(snp_addr)),
    .ent_valid    (valid_vec),
    .ent_line     (line_arr),
    .hit_vec_o    (hit_vec),
    .resp_valid_o (snp_resp_valid),
    .nack_o       (snp_nack)
  );

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    full && alloc_valid && !flush && !rel_valid |=> $stable(valid_vec)); // R6

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> valid_vec == '0); // R7

  AST_REJECT_UNQUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_valid && !admit_ok && !rel_valid && !flush |=> $stable(valid_vec)); // R1

  AST_NACK_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    snp_nack |-> $past(valid_vec) != '0); // R3

  AST_RELEASE_LEAVES_OTHERS: assert property (@(posedge clk) disable iff (!rst_n)
    rel_valid && !alloc_valid && !flush |=> valid_vec == ($past(valid_vec) & ~$past(rel_hit_vec))); // R5

endmodule

// File: tb/tb_reorder_addr_set.sv
module tb_reorder_addr_set;

  localparam int ADDR_W = 16;
  localparam int OFF_W  = 6;
  localparam int DEPTH  = 4;
  localparam int TAG_W  = 4;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              alloc_valid, alloc_reordered, alloc_nonspec;
  logic              alloc_is_store, alloc_data_written;
  logic [ADDR_W-1:0] alloc_addr;
  logic [TAG_W-1:0]  alloc_tag;
  logic              rel_valid;
  logic [TAG_W-1:0]  rel_tag;
  logic              flush;
  logic              snp_valid;
  logic [ADDR_W-1:0] snp_addr;
  logic              snp_resp_valid, snp_nack, full;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  reorder_addr_set #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .DEPTH(DEPTH), .TAG_W(TAG_W)) dut (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_addr(alloc_addr), .alloc_tag(alloc_tag),
    .alloc_reordered(alloc_reordered), .alloc_nonspec(alloc_nonspec),
    .alloc_is_store(alloc_is_store), .alloc_data_written(alloc_data_written),
    .rel_valid(rel_valid), .rel_tag(rel_tag), .flush(flush),
    .snp_valid(snp_valid), .snp_addr(snp_addr),
    .snp_resp_valid(snp_resp_valid), .snp_nack(snp_nack), .full(full)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  task automatic idle();
    alloc_valid = 0; alloc_reordered = 0; alloc_nonspec = 0;
    alloc_is_store = 0; alloc_data_written = 0;
    alloc_addr = '0; alloc_tag = '0;
    rel_valid = 0; rel_tag = '0; flush = 0; snp_valid = 0; snp_addr = '0;
  endtask

  task automatic drive_alloc(input logic [ADDR_W-1:0] a, input logic [TAG_W-1:0] t,
                             input logic reo, input logic nsp, input logic st, input logic wr);
    alloc_valid = 1; alloc_addr = a; alloc_tag = t;
    alloc_reordered = reo; alloc_nonspec = nsp; alloc_is_store = st; alloc_data_written = wr;
  endtask

  task automatic alloc(input logic [ADDR_W-1:0] a, input logic [TAG_W-1:0] t,
                       input logic reo, input logic nsp, input logic st, input logic wr);
    @(negedge clk); drive_alloc(a, t, reo, nsp, st, wr);
    @(negedge clk); idle();
  endtask

  task automatic release_tag(input logic [TAG_W-1:0] t);
    @(negedge clk); rel_valid = 1; rel_tag = t;
    @(negedge clk); idle();
  endtask

  task automatic do_flush();
    @(negedge clk); flush = 1;
    @(negedge clk); idle();
  endtask

  task automatic snoop(input logic [ADDR_W-1:0] a, input logic exp_nack, input string req);
    @(negedge clk); snp_valid = 1; snp_addr = a;
    @(negedge clk); idle();
    chk(req, "snoop resp_valid", snp_resp_valid, 1'b1);
    chk(req, $sformatf("snoop nack @%h", a), snp_nack, exp_nack);
  endtask

  task automatic t_reset();
    chk("R9", "full after reset", full, 1'b0);
    chk("R9", "resp_valid after reset", snp_resp_valid, 1'b0);
    chk("R9", "nack after reset", snp_nack, 1'b0);
    snoop(16'h0000, 1'b0, "R9");
  endtask

  task automatic t_admit();
    do_flush();
    alloc(16'h0100, 4'd1, 0, 1, 0, 0);
    snoop(16'h0100, 1'b0, "R1");
    alloc(16'h0200, 4'd2, 1, 0, 0, 0);
    snoop(16'h0200, 1'b0, "R1");
    alloc(16'h0300, 4'd3, 1, 1, 0, 0);
    snoop(16'h0300, 1'b1, "R1");
    alloc(16'h0400, 4'd4, 1, 1, 1, 1);
    snoop(16'h0400, 1'b0, "R2");
    alloc(16'h0500, 4'd5, 1, 1, 1, 0);
    snoop(16'h0500, 1'b1, "R2");
  endtask

  task automatic t_line();
    do_flush();
    alloc(16'h1240, 4'd1, 1, 1, 0, 0);
    snoop(16'h1240, 1'b1, "R3");
    snoop(16'h127F, 1'b1, "R3");
    snoop(16'h1280, 1'b0, "R4");
    snoop(16'h123F, 1'b0, "R4");
  endtask

  task automatic t_release();
    do_flush();
    alloc(16'h2000, 4'd1, 1, 1, 0, 0);
    alloc(16'h2040, 4'd2, 1, 1, 0, 0);
    alloc(16'h2080, 4'd3, 1, 1, 0, 0);
    release_tag(4'd2);
    snoop(16'h2040, 1'b0, "R5");
    snoop(16'h2000, 1'b1, "R5");
    snoop(16'h2080, 1'b1, "R5");
    release_tag(4'd3);
    snoop(16'h2080, 1'b0, "R5");
    snoop(16'h2000, 1'b1, "R5");
  endtask

  task automatic t_full();
    do_flush();
    for (int i = 0; i < DEPTH; i++) begin
      chk("R6", "not full while filling", full, 1'b0);
      alloc(16'h3000 + 16'(i * 64), 4'(8 + i), 1, 1, 0, 0);
    end
    chk("R6", "full at depth", full, 1'b1);
    alloc(16'h3F00, 4'd15, 1, 1, 0, 0);
    snoop(16'h3F00, 1'b0, "R6");
    snoop(16'h3000, 1'b1, "R6");
    release_tag(4'd9);
    chk("R6", "full drops after release", full, 1'b0);
  endtask

  task automatic t_flush();
    alloc(16'h4000, 4'd1, 1, 1, 0, 0);
    @(negedge clk); flush = 1; drive_alloc(16'h4400, 4'd2, 1, 1, 0, 0);
    @(negedge clk); idle();
    chk("R7", "full after flush", full, 1'b0);
    snoop(16'h4000, 1'b0, "R7");
    snoop(16'h3000, 1'b0, "R7");
    snoop(16'h4400, 1'b0, "R7");
  endtask

  task automatic t_timing();
    do_flush();
    @(negedge clk); drive_alloc(16'h5000, 4'd1, 1, 1, 0, 0); snp_valid = 1; snp_addr = 16'h5000;
    @(negedge clk); idle();
    chk("R8", "same-cycle alloc not seen", snp_nack, 1'b0);
    chk("R8", "resp_valid next cycle", snp_resp_valid, 1'b1);
    @(negedge clk);
    chk("R8", "resp_valid drops", snp_resp_valid, 1'b0);
    @(negedge clk); rel_valid = 1; rel_tag = 4'd1; snp_valid = 1; snp_addr = 16'h5000;
    @(negedge clk); idle();
    chk("R8", "same-cycle release still seen", snp_nack, 1'b1);
    snoop(16'h5000, 1'b0, "R8");
    alloc(16'h5100, 4'd2, 1, 1, 0, 0);
    @(negedge clk); flush = 1; snp_valid = 1; snp_addr = 16'h5100;
    @(negedge clk); idle();
    chk("R8", "same-cycle flush still seen", snp_nack, 1'b1);
  endtask

  initial begin
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_admit();
    t_line();
    t_release();
    t_full();
    t_flush();
    t_timing();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

endmodule